// File: doc/BRIEF.md
# Link Control Register with Stopped-Clock Access Guard

This block is the host-side control register of a serial-bus link layer. Software reaches the control word through two addresses. Writing ones to the set address turns bits on, and writing ones to the clear address turns them off. Both addresses read back the live value. The word holds five things: a self-timed soft reset, a link enable, a posted-write enable, a link power status bit and a PHY enhancement enable. The last two guarded bits only move under conditions that the register checks for itself. The block also holds a 2 KB aligned base pointer for the self-ID buffer.

The same block answers every host access that falls into the PHY clock domain. While the PHY clock runs, such an access is passed on to that domain. While the clock is stopped, the access either ends with an abort or, when a configuration input asks for it, completes quietly and reads as all ones. Every request gets its registered response exactly one cycle later.

Top module: `link_ctl_regs`

## Requirements
- R1: After reset, the control word and the self-ID pointer read 0, `link_en`, `posted_wr_en`, `link_pwr`, `phy_enh_en` and `soft_rst_busy` are 0, and `hb_ack` and `hb_abort` are 0 while no request is made.
- R2: Control bit positions are: soft reset 16, link enable 17, posted-write enable 18, link power 19, PHY enhancement enable 22, and bit 23 mirrors the `prog_phy_ok` input. A write to the set address (050h) sets each bit written as 1. A write to the clear address (054h) clears each bit written as 1. Bits written as 0 keep their value. A read of either address returns the current word.
- R3: A set request for bit 22 takes effect only when `prog_phy_ok` is 1 and link enable is already 1 before the write. Otherwise the bit stays unchanged. Clearing bit 22 is always accepted.
- R4: Posted-write enable changes, by set or by clear, only while link enable is 0 before the write. Requests made while link enable is 1 are ignored.
- R5: Writing 1 to bit 16 at the set address starts a soft reset. Bit 16 and `soft_rst_busy` then read 1 for exactly 16 cycles and return to 0 by themselves. The soft reset clears link enable, posted-write enable, link power, PHY enhancement enable and the self-ID pointer. Writes to the control word or the pointer during the reset are ignored. Writing 1 to bit 16 at the clear address does nothing.
- R6: Bits 31 to 24, 21 and 20, and 15 to 0 of the control word always read 0.
- R7: The self-ID pointer at 064h stores write bits 31 to 11. Bits 10 to 0 always read 0, and `sid_base` shows the stored value.
- R8: An access to the PHY windows (aligned addresses 0DCh to 0F0h and 100h to 11Ch, inclusive) while `phy_clk_run` is 0 and `abort_disable` is 0 is answered with `hb_ack` and `hb_abort` both 1 and `hb_rdata` 0.
- R9: The same access with `abort_disable` at 1 completes without abort. A read returns FFFFFFFFh and a write is dropped.
- R10: While `phy_clk_run` is 1, a PHY-window request raises `phy_req` in the same cycle, and a read returns the `phy_rdata` value sampled at that edge. Addresses outside the windows never raise `phy_req`, never abort, and read 0 unless they are the control or pointer addresses.
- R11: `hb_ack` is 1 in the cycle after each cycle with `hb_req` at 1, and 0 otherwise. `hb_rdata` is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low hardware reset |
| hb_req | input | 1 | Host access request, one cycle per access |
| hb_we | input | 1 | 1 for write, 0 for read |
| hb_addr | input | 12 | Byte address of the access |
| hb_wdata | input | 32 | Write data |
| hb_ack | output | 1 | Registered completion, one cycle after the request |
| hb_abort | output | 1 | Completion is an abort |
| hb_rdata | output | 32 | Read data, valid with `hb_ack` |
| phy_clk_run | input | 1 | PHY-domain clock is running |
| abort_disable | input | 1 | Stopped-clock accesses complete with all ones instead of aborting |
| prog_phy_ok | input | 1 | PHY enhancement programming allowed, shown at bit 23 |
| phy_req | output | 1 | Access forwarded to the PHY clock domain |
| phy_rdata | input | 32 | Read data from the PHY clock domain |
| soft_rst_busy | output | 1 | Soft reset in progress (flushes the FIFOs) |
| link_en | output | 1 | Link enable; while 0, no packets move |
| posted_wr_en | output | 1 | Posted writes enabled |
| link_pwr | output | 1 | Link power status; while 0, link-PHY traffic is blocked |
| phy_enh_en | output | 1 | PHY enhancements enabled |
| sid_base | output | 32 | Self-ID buffer base address |

## Verification
The bench targets the window edges: 0D8h, 0DCh, 0F0h, 0F4h, 0FCh, 100h, 11Ch and 120h. An off-by-one decoder would abort a harmless register or pass a stopped-clock access through. It sets the PHY enhancement bit with link enable 0, with `prog_phy_ok` 0, and in the same write that sets link enable. A gate that looked at the new link value would then turn on enhancements too early. It writes the posted-write bit while the link is live, and it writes during a soft reset. It also counts the reset cycles, so a counter that is off by one, that lets writes through or that fails to clear the pointer is caught.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

   localparam int unsigned BIT_SRST = 16;
   localparam int unsigned BIT_LINK = 17;
   localparam int unsigned BIT_POST = 18;
   localparam int unsigned BIT_LPS  = 19;
   localparam int unsigned BIT_ENH  = 22;
   localparam int unsigned BIT_PROG = 23;

   typedef struct packed {
      logic enh;
      logic lps;
      logic post;
      logic link;
   } ctrl_t;

   typedef enum logic [2:0] {
      SRC_ZERO,
      SRC_CTRL,
      SRC_SID,
      SRC_PHY,
      SRC_ONES
   } rsrc_e;

   function automatic logic [31:0] pack_ctrl(input ctrl_t c, input logic busy,
                                             input logic prog);
      logic [31:0] w;
      w           = '0;
      w[BIT_SRST] = busy;
      w[BIT_LINK] = c.link;
      w[BIT_POST] = c.post;
      w[BIT_LPS]  = c.lps;
      w[BIT_ENH]  = c.enh;
      w[BIT_PROG] = prog;
      return w;
   endfunction

endpackage

// File: rtl/lcr_decode.sv
module lcr_decode #(
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] SET_OFS = 12'h050,
   parameter logic [ADDR_W-1:0] CLR_OFS = 12'h054,
   parameter logic [ADDR_W-1:0] SID_OFS = 12'h064,
   parameter int unsigned NUM_WIN = 2,
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {12'h100, 12'h0DC},
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {12'h11C, 12'h0F0}
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_set,
   output logic              hit_clr,
   output logic              hit_sid,
   output logic              hit_phy
);

   logic               aligned;
   logic [NUM_WIN-1:0] win_hit;

   assign aligned = (addr[1:0] == 2'b00);

   generate
      for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
         localparam logic [ADDR_W-1:0] LO = WIN_LO[gi*ADDR_W +: ADDR_W];
         localparam logic [ADDR_W-1:0] HI = WIN_HI[gi*ADDR_W +: ADDR_W];
         assign win_hit[gi] = (addr >= LO) && (addr <= HI);
      end
   endgenerate

   assign hit_set = aligned && (addr == SET_OFS);
   assign hit_clr = aligned && (addr == CLR_OFS);
   assign hit_sid = aligned && (addr == SID_OFS);
   assign hit_phy = aligned && (|win_hit);

endmodule

// File: rtl/lcr_rst_seq.sv
module lcr_rst_seq #(
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   generate
      if (RST_CYCLES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy <= 1'b0;
            else        busy <= start;
         end
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(RST_CYCLES);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy  <= 1'b0;
               cnt_q <= '0;
            end else if (start) begin
               busy  <= 1'b1;
               cnt_q <= LAST;
            end else if (busy) begin
               if (cnt_q == '0) busy <= 1'b0;
               else             cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lcr_ctrl_reg.sv
module lcr_ctrl_reg
   import lcr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  busy,
   input  logic  wr_set,
   input  logic  wr_clr,
   input  logic  prog_ok,
   input  ctrl_t req_bits,
   output ctrl_t q
);

   ctrl_t nxt;
   logic  post_open;
   logic  enh_open;

   // Guards look at the value held before this write.
   assign post_open = !q.link;
   assign enh_open  = q.link && prog_ok;

   always_comb begin
      nxt = q;
      if (wr_set) begin
         nxt.link = q.link | req_bits.link;
         nxt.lps  = q.lps  | req_bits.lps;
         if (post_open && req_bits.post) nxt.post = 1'b1;
         if (enh_open  && req_bits.enh)  nxt.enh  = 1'b1;
      end else if (wr_clr) begin
         nxt.link = q.link & ~req_bits.link;
         nxt.lps  = q.lps  & ~req_bits.lps;
         nxt.enh  = q.enh  & ~req_bits.enh;
         if (post_open && req_bits.post) nxt.post = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (start)   q <= '0;
      else if (!busy)   q <= nxt;
   end

endmodule

// File: rtl/lcr_guard.sv
module lcr_guard
   import lcr_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic              hit_ctrl,
   input  logic              hit_sid,
   input  logic              hit_phy,
   input  logic              phy_clk_run,
   input  logic              abort_disable,
   input  logic [DATA_W-1:0] ctrl_rd,
   input  logic [DATA_W-1:0] sid_rd,
   input  logic [DATA_W-1:0] phy_rdata,
   output logic              phy_req,
   output logic              ack,
   output logic              abort,
   output logic [DATA_W-1:0] rdata
);

   rsrc_e             src;
   logic              abort_d;
   logic [DATA_W-1:0] rdata_d;

   assign phy_req = req && hit_phy && phy_clk_run;
   assign abort_d = req && hit_phy && !phy_clk_run && !abort_disable;

   always_comb begin
      src = SRC_ZERO;
      if (req && !we) begin
         if (hit_phy) begin
            if (phy_clk_run)        src = SRC_PHY;
            else if (abort_disable) src = SRC_ONES;
            else                    src = SRC_ZERO;
         end else if (hit_ctrl) begin
            src = SRC_CTRL;
         end else if (hit_sid) begin
            src = SRC_SID;
         end
      end
   end

   always_comb begin
      unique case (src)
         SRC_CTRL: rdata_d = ctrl_rd;
         SRC_SID:  rdata_d = sid_rd;
         SRC_PHY:  rdata_d = phy_rdata;
         SRC_ONES: rdata_d = '1;
         default:  rdata_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack   <= 1'b0;
         abort <= 1'b0;
         rdata <= '0;
      end else begin
         ack   <= req;
         abort <= abort_d;
         rdata <= rdata_d;
      end
   end

endmodule

// File: rtl/link_ctl_regs.sv
module link_ctl_regs
   import lcr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned RST_CYCLES = 16,
   parameter int unsigned SID_ALIGN  = 11,
   parameter logic [ADDR_W-1:0] SET_OFS = 12'h050,
   parameter logic [ADDR_W-1:0] CLR_OFS = 12'h054,
   parameter logic [ADDR_W-1:0] SID_OFS = 12'h064,
   parameter int unsigned NUM_WIN = 2,
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO = {12'h100, 12'h0DC},
   parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI = {12'h11C, 12'h0F0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hb_req,
   input  logic              hb_we,
   input  logic [ADDR_W-1:0] hb_addr,
   input  logic [DATA_W-1:0] hb_wdata,
   output logic              hb_ack,
   output logic              hb_abort,
   output logic [DATA_W-1:0] hb_rdata,
   input  logic              phy_clk_run,
   input  logic              abort_disable,
   input  logic              prog_phy_ok,
   output logic              phy_req,
   input  logic [DATA_W-1:0] phy_rdata,
   output logic              soft_rst_busy,
   output logic              link_en,
   output logic              posted_wr_en,
   output logic              link_pwr,
   output logic              phy_enh_en,
   output logic [DATA_W-1:0] sid_base
);

   localparam int unsigned SID_W = DATA_W - SID_ALIGN;

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("link_ctl_regs: DATA_W must be 32");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("link_ctl_regs: ADDR_W too small");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("link_ctl_regs: RST_CYCLES must be at least 1");
      end
      if (SID_ALIGN < 2 || SID_ALIGN > 16) begin : g_bad_align
         $error("link_ctl_regs: SID_ALIGN out of range");
      end
      if (NUM_WIN < 1) begin : g_bad_win
         $error("link_ctl_regs: NUM_WIN must be at least 1");
      end
   endgenerate

   logic  hit_set, hit_clr, hit_sid, hit_phy;
   logic  wr_set, wr_clr, wr_sid, start;
   ctrl_t req_bits;
   ctrl_t ctrl_q;
   logic  [SID_W-1:0]  sid_q;
   logic  [DATA_W-1:0] ctrl_rd;
   logic  unused_wdata;

   lcr_decode #(
      .ADDR_W (ADDR_W),
      .SET_OFS(SET_OFS),
      .CLR_OFS(CLR_OFS),
      .SID_OFS(SID_OFS),
      .NUM_WIN(NUM_WIN),
      .WIN_LO (WIN_LO),
      .WIN_HI (WIN_HI)
   ) u_dec (
      .addr   (hb_addr),
      .hit_set(hit_set),
      .hit_clr(hit_clr),
      .hit_sid(hit_sid),
      .hit_phy(hit_phy)
   );

   assign wr_set = hb_req && hb_we && hit_set && !soft_rst_busy;
   assign wr_clr = hb_req && hb_we && hit_clr && !soft_rst_busy;
   assign wr_sid = hb_req && hb_we && hit_sid && !soft_rst_busy;
   assign start  = wr_set && hb_wdata[BIT_SRST];

   assign req_bits.link = hb_wdata[BIT_LINK];
   assign req_bits.post = hb_wdata[BIT_POST];
   assign req_bits.lps  = hb_wdata[BIT_LPS];
   assign req_bits.enh  = hb_wdata[BIT_ENH];

   lcr_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .busy (soft_rst_busy)
   );

   lcr_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .busy    (soft_rst_busy),
      .wr_set  (wr_set),
      .wr_clr  (wr_clr),
      .prog_ok (prog_phy_ok),
      .req_bits(req_bits),
      .q       (ctrl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sid_q <= '0;
      else if (start)  sid_q <= '0;
      else if (wr_sid) sid_q <= hb_wdata[DATA_W-1:SID_ALIGN];
   end

   assign sid_base     = {sid_q, {SID_ALIGN{1'b0}}};
   assign ctrl_rd      = pack_ctrl(ctrl_q, soft_rst_busy, prog_phy_ok);
   assign link_en      = ctrl_q.link;
   assign posted_wr_en = ctrl_q.post;
   assign link_pwr     = ctrl_q.lps;
   assign phy_enh_en   = ctrl_q.enh;
   assign unused_wdata = ^hb_wdata[SID_ALIGN-1:0];

   lcr_guard #(.DATA_W(DATA_W)) u_guard (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (hb_req),
      .we           (hb_we),
      .hit_ctrl     (hit_set || hit_clr),
      .hit_sid      (hit_sid),
      .hit_phy      (hit_phy),
      .phy_clk_run  (phy_clk_run),
      .abort_disable(abort_disable),
      .ctrl_rd      (ctrl_rd),
      .sid_rd       (sid_base),
      .phy_rdata    (phy_rdata),
      .phy_req      (phy_req),
      .ack          (hb_ack),
      .abort        (hb_abort),
      .rdata        (hb_rdata)
   );

endmodule

// File: rtl/lcr_chk.sv
module lcr_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hb_req,
   input logic              hb_ack,
   input logic              hb_abort,
   input logic [DATA_W-1:0] hb_rdata,
   input logic              phy_clk_run,
   input logic              prog_phy_ok,
   input logic              phy_req,
   input logic              soft_rst_busy,
   input logic              link_en,
   input logic              posted_wr_en,
   input logic              link_pwr,
   input logic              phy_enh_en
);

   // R11
   ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hb_req |=> hb_ack);

   // R11
   no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hb_req |=> !hb_ack);

   // R8
   abort_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hb_abort |-> (hb_ack && hb_rdata == '0));

   // R10
   phy_fwd_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req |-> (hb_req && phy_clk_run));

   // R3
   enh_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_enh_en) |-> ($past(link_en) && $past(prog_phy_ok)));

   // R4
   post_change_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(posted_wr_en) |-> (!$past(link_en) || soft_rst_busy));

   // R5
   reset_clears_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_busy |-> !(link_en || posted_wr_en || link_pwr || phy_enh_en));

endmodule

bind link_ctl_regs lcr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hb_req       (hb_req),
   .hb_ack       (hb_ack),
   .hb_abort     (hb_abort),
   .hb_rdata     (hb_rdata),
   .phy_clk_run  (phy_clk_run),
   .prog_phy_ok  (prog_phy_ok),
   .phy_req      (phy_req),
   .soft_rst_busy(soft_rst_busy),
   .link_en      (link_en),
   .posted_wr_en (posted_wr_en),
   .link_pwr     (link_pwr),
   .phy_enh_en   (phy_enh_en)
);

// File: tb/sim_link_ctl_regs.sv
`timescale 1ns/1ps
module sim_link_ctl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hb_req = 1'b0, hb_we = 1'b0;
   logic [11:0] hb_addr = '0;
   logic [31:0] hb_wdata = '0;
   logic        hb_ack, hb_abort;
   logic [31:0] hb_rdata;
   logic        phy_clk_run = 1'b0, abort_disable = 1'b0, prog_phy_ok = 1'b0;
   logic        phy_req;
   logic [31:0] phy_rdata = '0;
   logic        soft_rst_busy, link_en, posted_wr_en, link_pwr, phy_enh_en;
   logic [31:0] sid_base;

   int unsigned vecs = 0, bad = 0;
   bit          done = 1'b0;

   // model state
   bit          m_link, m_post, m_lps, m_enh;
   logic [31:0] m_sid;

   // captured response
   logic        s_ack, s_abort, s_phyreq;
   logic [31:0] s_rdata;

   always #5 clk = ~clk;

   link_ctl_regs u0 (.*);

   localparam logic [11:0] A_SET = 12'h050, A_CLR = 12'h054, A_SID = 12'h064;

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_ctrl();
      logic [31:0] w = '0;
      w[17] = m_link; w[18] = m_post; w[19] = m_lps; w[22] = m_enh; w[23] = prog_phy_ok;
      return w;
   endfunction

   function automatic bit in_phy(input logic [11:0] a);
      return (a[1:0] == 2'b00) && ((a >= 12'h0DC && a <= 12'h0F0) ||
                                   (a >= 12'h100 && a <= 12'h11C));
   endfunction

   function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
      bit old = m_link;
      if (a == A_SET) begin
         m_link |= d[17];
         m_lps  |= d[19];
         if (!old && d[18]) m_post = 1'b1;
         if (old && prog_phy_ok && d[22]) m_enh = 1'b1;
      end else if (a == A_CLR) begin
         m_link &= ~d[17];
         m_lps  &= ~d[19];
         m_enh  &= ~d[22];
         if (!old && d[18]) m_post = 1'b0;
      end else if (a == A_SID) begin
         m_sid = {d[31:11], 11'b0};
      end
   endfunction

   task automatic acc(input logic we, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      hb_req = 1'b1; hb_we = we; hb_addr = a; hb_wdata = d;
      #1 s_phyreq = phy_req;
      @(posedge clk);
      #2;
      s_ack = hb_ack; s_abort = hb_abort; s_rdata = hb_rdata;
      hb_req = 1'b0; hb_we = 1'b0;
   endtask

   task automatic check_pins(input string rq);
      check({rq, " link_en"},      {31'b0, link_en},      {31'b0, m_link});
      check({rq, " posted_wr_en"}, {31'b0, posted_wr_en}, {31'b0, m_post});
      check({rq, " link_pwr"},     {31'b0, link_pwr},     {31'b0, m_lps});
      check({rq, " phy_enh_en"},   {31'b0, phy_enh_en},   {31'b0, m_enh});
      check({rq, " sid_base"},     sid_base,              m_sid);
   endtask

   task automatic rd_ctrl(input string rq);
      acc(1'b0, A_SET, '0);
      check({rq, " ack"}, {31'b0, s_ack}, 32'd1);
      check({rq, " ctrl read"}, s_rdata, exp_ctrl());
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      acc(1'b1, a, d);
      model_write(a, d);
   endtask

   // phy-window access with full expectation
   task automatic phy_op(input logic we, input logic [11:0] a, input logic run,
                         input logic dis, input logic [31:0] pd);
      bit hit = in_phy(a);
      logic [31:0] er;
      phy_clk_run = run; abort_disable = dis; phy_rdata = pd;
      acc(we, a, pd);
      er = '0;
      if (!we && hit && run) er = pd;
      if (!we && hit && !run && dis) er = '1;
      check("R11 ack", {31'b0, s_ack}, 32'd1);
      check(hit && run ? "R10 phy_req" : "R10 no phy_req", {31'b0, s_phyreq}, {31'b0, hit && run});
      check("R8 abort", {31'b0, s_abort}, {31'b0, hit && !run && !dis});
      check(dis ? "R9 rdata" : "R8/R10 rdata", s_rdata, er);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      m_link = 0; m_post = 0; m_lps = 0; m_enh = 0; m_sid = '0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;

      // R1 reset state
      check("R1 ack idle", {30'b0, hb_ack, hb_abort}, 32'd0);
      check("R1 busy", {31'b0, soft_rst_busy}, 32'd0);
      check_pins("R1");
      rd_ctrl("R1");
      acc(1'b0, A_SID, '0);
      check("R1 sid read", s_rdata, 32'd0);
      @(posedge clk); #2;
      check("R11 ack drops", {31'b0, hb_ack}, 32'd0);

      // R3 gating: link 0, prog 1 -> ignored
      prog_phy_ok = 1'b1;
      wr(A_SET, 32'h0040_0000);
      rd_ctrl("R3 enh with link off");
      // set link and enh in the same write: enh uses old link -> ignored
      wr(A_SET, 32'h0042_0000);
      rd_ctrl("R3 enh same write as link");
      check_pins("R3");
      // prog 0, link 1 -> ignored
      prog_phy_ok = 1'b0;
      wr(A_SET, 32'h0040_0000);
      rd_ctrl("R3 enh with prog off");
      prog_phy_ok = 1'b1;
      wr(A_SET, 32'h0040_0000);
      rd_ctrl("R3 enh accepted");
      check("R3 enh pin", {31'b0, phy_enh_en}, 32'd1);

      // R4 posted gating while link live
      wr(A_SET, 32'h0004_0000);
      rd_ctrl("R4 post set while link on");
      check("R4 post pin", {31'b0, posted_wr_en}, 32'd0);
      wr(A_CLR, 32'h0002_0000);
      wr(A_SET, 32'h0004_0000);
      rd_ctrl("R4 post set while link off");
      wr(A_SET, 32'h0002_0000);
      wr(A_CLR, 32'h0004_0000);
      rd_ctrl("R4 post clear while link on");
      check_pins("R4");

      // R2 zeros keep, clear address readback, R6 reserved
      wr(A_SET, 32'hFF3F_0000 & ~32'h0001_0000);
      acc(1'b0, A_CLR, '0);
      check("R2 clear addr readback", s_rdata, exp_ctrl());
      wr(A_SET, 32'hFF30_FFFF & ~32'h0001_0000);
      rd_ctrl("R6 reserved read 0");
      wr(A_CLR, 32'h0008_0000);
      rd_ctrl("R2 clear one bit");
      check("R11 write rdata", s_rdata, exp_ctrl());
      acc(1'b1, A_CLR, 32'h0);
      model_write(A_CLR, 32'h0);
      check("R11 write returns 0", s_rdata, 32'd0);

      // R7 pointer alignment
      wr(A_SID, 32'hFFFF_FFFF);
      acc(1'b0, A_SID, '0);
      check("R7 sid read", s_rdata, 32'hFFFF_F800);
      check_pins("R7");

      // R8..R10 window edges
      phy_op(1'b0, 12'h0D8, 1'b0, 1'b0, 32'h1111_2222);
      phy_op(1'b0, 12'h0DC, 1'b0, 1'b0, 32'h1111_2222);
      phy_op(1'b0, 12'h0F0, 1'b0, 1'b1, 32'h1111_2222);
      phy_op(1'b0, 12'h0F4, 1'b0, 1'b0, 32'h1111_2222);
      phy_op(1'b0, 12'h0FC, 1'b0, 1'b0, 32'h1111_2222);
      phy_op(1'b0, 12'h100, 1'b1, 1'b0, 32'hA5A5_0F0F);
      phy_op(1'b1, 12'h11C, 1'b0, 1'b1, 32'hDEAD_BEEF);
      phy_op(1'b0, 12'h11C, 1'b1, 1'b0, 32'h1234_5678);
      phy_op(1'b0, 12'h120, 1'b1, 1'b0, 32'h1234_5678);
      check_pins("R9 write dropped");

      // R5 soft reset
      wr(A_SET, 32'h0008_0000);
      acc(1'b1, A_SET, 32'h0001_0000);
      begin
         int unsigned cyc = 0;
         if (soft_rst_busy) cyc = 1;
         m_link = 0; m_post = 0; m_lps = 0; m_enh = 0; m_sid = '0;
         check_pins("R5 cleared");
         acc(1'b0, A_SET, '0);
         check("R5 bit16 reads 1", s_rdata, exp_ctrl() | 32'h0001_0000);
         cyc++;
         acc(1'b1, A_SET, 32'h000A_0000);
         cyc++;
         acc(1'b1, A_SID, 32'hFFFF_FFFF);
         cyc++;
         while (soft_rst_busy && cyc < 100) begin
            @(posedge clk); #2;
            if (soft_rst_busy) cyc++;
         end
         check("R5 busy length", cyc, 32'd16);
      end
      rd_ctrl("R5 writes during reset ignored");
      check_pins("R5 after reset");
      wr(A_CLR, 32'h0001_0000);
      check("R5 clear addr bit16", {31'b0, soft_rst_busy}, 32'd0);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned op = $urandom_range(0, 5);
         prog_phy_ok = 1'($urandom_range(0, 1));
         case (op)
            0: wr(A_SET, $urandom() & ~32'h0001_0000);
            1: wr(A_CLR, $urandom());
            2: rd_ctrl("R2 random read");
            3: begin
               wr(A_SID, $urandom());
               acc(1'b0, A_SID, '0);
               check("R7 random sid", s_rdata, m_sid);
            end
            default: phy_op(1'($urandom_range(0, 1)),
                            12'h0C0 + 12'($urandom_range(0, 31) * 4),
                            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                            $urandom());
         endcase
         if (op <= 1) check_pins("R2 random pins");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vecs++;
         bad++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

endmodule